// File: doc/BRIEF.md
# Absolute Encoder Position Read Master

This block is the controller end of a clocked two-way serial link to an absolute position encoder. A start request begins one position read. The block first pulls the serial clock low. It waits two serial periods while the encoder freezes its position, then drives a fixed 6-bit mode command. It then releases the data line and looks for the encoder's start bit. After the start bit it shifts in two error flags, a position word and a check field.

The serial clock comes from the system clock through an enable-based divider. Each serial half period is a parameterised number of system cycles. The controller changes its output bit on falling serial edges and samples the encoder on rising serial edges. When the frame ends, the captured fields, the check result and a done pulse all appear together. The serial clock then stays high. No new read can begin until the encoder releases the data line back to low. If no start bit arrives within a programmable number of serial periods, the read is abandoned and a timeout pulse is raised.

Top module: `abs_enc_reader`

## Requirements
- R1: After reset, sclk_o is 1, enc_oe is 0, enc_dout is 0, and done_o, crc_ok_o and timeout_o are 0.
- R2: While idle, sclk_o is held at 1. After an accepted start request, sclk_o toggles every HALF_DIV system cycles, starting with a falling edge, so one serial period is 2*HALF_DIV system cycles.
- R3: In serial periods 1 and 2 (counted from the first falling edge), enc_oe is 1 and enc_dout is 0.
- R4: In serial periods 3 to 8, enc_oe is 1 and enc_dout carries the command 0,0,0,1,1,1 in that order (bit 5 of 6'b000111 first). enc_dout changes only at falling serial edges.
- R5: At the 9th falling edge, enc_oe drops to 0 and stays 0 until the next read.
- R6: The start bit is the first rising serial edge after the turnaround at which enc_din is 1. The 30 rising edges that follow each capture one response bit.
- R7: The response order is F1, then F2, then POS_W position bits least significant bit first, then CRC_W check bits most significant bit first. These fields appear on f1_o, f2_o, pos_o and crc_rx_o.
- R8: The check value uses the shift form r = (r<<1) ^ (r[4]^b ? CRC_POLY : 0), starting from CRC_INIT, over F1, F2 and the position bits in arrival order. crc_ok_o is 1 during the done pulse exactly when this value equals the received field, and is 0 at all other times.
- R9: done_o is a single-cycle pulse, and all captured outputs change on the same cycle that done_o rises. A read with start delay d produces exactly 39+d falling edges, and sclk_o stays 1 afterwards.
- R10: If TIMEOUT_P rising edges pass after the turnaround with enc_din at 0, timeout_o pulses for one cycle and the block returns to idle. done_o does not pulse, pos_o is unchanged, and the total is 8+TIMEOUT_P falling edges.
- R11: A start request that arrives during a read, or while waiting for recovery, is ignored: it produces no extra falling edge.
- R12: After a read, the block accepts a new start only once enc_din has been seen at 0 (encoder recovery complete).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request one position read (used only when idle) |
| enc_din | input | 1 | Serial data from encoder |
| sclk_o | output | 1 | Serial clock to encoder, idles high |
| enc_dout | output | 1 | Serial data to encoder |
| enc_oe | output | 1 | Output enable for enc_dout |
| pos_o | output | POS_W | Captured position word |
| f1_o | output | 1 | First error flag |
| f2_o | output | 1 | Second error flag |
| crc_rx_o | output | 5 | Received check field |
| crc_ok_o | output | 1 | Check match, valid with done_o |
| done_o | output | 1 | One-cycle frame-complete pulse |
| timeout_o | output | 1 | One-cycle start-bit timeout pulse |

## Verification
The bench builds the block with HALF_DIV=2 and TIMEOUT_P=8, while keeping the full 23-bit position. This shortens each read to about 160 system cycles, so every legal start-bit delay from 0 to 7 periods can be swept, along with the first illegal delay of 8. Positions cover walking ones, all ones, zero and a pseudo-random series, with both flag values and both good and corrupted check fields. The expected check value is computed in the bench by polynomial long division rather than by a shift register.

// File: rtl/abs_enc_pkg.sv
package abs_enc_pkg;

  localparam int CRCW = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LATCH,
    ST_CMD,
    ST_WAIT,
    ST_RECV,
    ST_FIN,
    ST_REC
  } rd_state_t;

  // one serial step of the check register
  function automatic logic [CRCW-1:0] crc_step(input logic [CRCW-1:0] r,
                                               input logic b,
                                               input logic [CRCW-1:0] poly);
    logic fb;
    fb = r[CRCW-1] ^ b;
    return {r[CRCW-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

endpackage

// File: rtl/sclk_div.sv
module sclk_div #(
  parameter int HALF_DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk_o,
  output logic fall_evt,
  output logic rise_evt
);
  localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);

  logic [CW-1:0] cnt;
  logic          sclk_q;
  logic          wrap;

  assign wrap     = run && (cnt == CW'(HALF_DIV - 1));
  assign fall_evt = wrap && sclk_q;
  assign rise_evt = wrap && !sclk_q;
  assign sclk_o   = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_q <= 1'b1;
    end else if (!run) begin
      cnt    <= '0;
      sclk_q <= 1'b1;
    end else if (wrap) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> sclk_q);

endmodule

// File: rtl/crc_ser.sv
module crc_ser
  import abs_enc_pkg::*;
#(
  parameter logic [CRCW-1:0] POLY = 5'h05,
  parameter logic [CRCW-1:0] INIT = 5'h1F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic            bit_i,
  output logic [CRCW-1:0] crc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_o <= INIT;
    else if (clr) crc_o <= INIT;
    else if (en)  crc_o <= crc_step(crc_o, bit_i, POLY);
  end
endmodule

// File: rtl/field_unpack.sv
module field_unpack
  import abs_enc_pkg::*;
#(
  parameter int POS_W  = 23,
  parameter int RESP_W = 2 + POS_W + CRCW
) (
  input  logic [RESP_W-1:0] resp,
  output logic              f1,
  output logic              f2,
  output logic [POS_W-1:0]  pos,
  output logic [CRCW-1:0]   crc_rx
);
  // bit k of resp is the k-th bit after the start bit
  assign f1  = resp[0];
  assign f2  = resp[1];
  assign pos = resp[2 +: POS_W];

  for (genvar j = 0; j < CRCW; j++) begin : g_crc
    assign crc_rx[CRCW-1-j] = resp[2+POS_W+j];
  end
endmodule

// File: rtl/abs_enc_reader.sv
module abs_enc_reader
  import abs_enc_pkg::*;
#(
  parameter int              HALF_DIV  = 25,
  parameter int              POS_W     = 23,
  parameter int              CMD_W     = 6,
  parameter logic [CMD_W-1:0] CMD_WORD = 6'b000111,
  parameter int              LATCH_P   = 2,
  parameter int              TIMEOUT_P = 64,
  parameter logic [CRCW-1:0] CRC_POLY  = 5'h05,
  parameter logic [CRCW-1:0] CRC_INIT  = 5'h1F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             enc_din,
  output logic             sclk_o,
  output logic             enc_dout,
  output logic             enc_oe,
  output logic [POS_W-1:0] pos_o,
  output logic             f1_o,
  output logic             f2_o,
  output logic [CRCW-1:0]  crc_rx_o,
  output logic             crc_ok_o,
  output logic             done_o,
  output logic             timeout_o
);
  localparam int MSG_W  = 2 + POS_W;
  localparam int RESP_W = MSG_W + CRCW;
  localparam int M1     = (LATCH_P > CMD_W) ? LATCH_P : CMD_W;
  localparam int M2     = (M1 > TIMEOUT_P) ? M1 : TIMEOUT_P;
  localparam int MAXC   = (M2 > RESP_W) ? M2 : RESP_W;
  localparam int CNT_W  = $clog2(MAXC + 1);

  rd_state_t          state;
  logic [CNT_W-1:0]   cnt;
  logic [CMD_W-1:0]   cmd_sh;
  logic [RESP_W-1:0]  resp_q;
  logic               dout_q, oe_q;
  logic               done_q, crc_ok_q, to_q;
  logic [POS_W-1:0]   pos_q;
  logic               f1_q, f2_q;
  logic [CRCW-1:0]    crc_rx_q;

  // named internal events
  logic               run_w;
  logic               fall_evt, rise_evt;
  logic               accept_w;
  logic               crc_en_w;
  logic [CRCW-1:0]    crc_acc;
  logic               f1_w, f2_w;
  logic [POS_W-1:0]   pos_w;
  logic [CRCW-1:0]    crc_rx_w;

  assign run_w    = (state == ST_LATCH) || (state == ST_CMD) ||
                    (state == ST_WAIT)  || (state == ST_RECV);
  assign accept_w = (state == ST_IDLE) && start_req;
  assign crc_en_w = (state == ST_RECV) && rise_evt && (cnt < CNT_W'(MSG_W));

  sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .sclk_o   (sclk_o),
    .fall_evt (fall_evt),
    .rise_evt (rise_evt)
  );

  crc_ser #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept_w),
    .en    (crc_en_w),
    .bit_i (enc_din),
    .crc_o (crc_acc)
  );

  field_unpack #(.POS_W(POS_W), .RESP_W(RESP_W)) u_unpack (
    .resp   (resp_q),
    .f1     (f1_w),
    .f2     (f2_w),
    .pos    (pos_w),
    .crc_rx (crc_rx_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      cmd_sh   <= '0;
      resp_q   <= '0;
      dout_q   <= 1'b0;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
      crc_ok_q <= 1'b0;
      to_q     <= 1'b0;
      pos_q    <= '0;
      f1_q     <= 1'b0;
      f2_q     <= 1'b0;
      crc_rx_q <= '0;
    end else begin
      done_q   <= 1'b0;
      crc_ok_q <= 1'b0;
      to_q     <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_req) begin
            state  <= ST_LATCH;
            cnt    <= '0;
            oe_q   <= 1'b1;
            dout_q <= 1'b0;
          end
        end
        ST_LATCH: begin
          if (fall_evt) begin
            if (cnt == CNT_W'(LATCH_P)) begin
              state  <= ST_CMD;
              dout_q <= CMD_WORD[CMD_W-1];
              cmd_sh <= CMD_WORD << 1;
              cnt    <= CNT_W'(1);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_CMD: begin
          if (fall_evt) begin
            if (cnt == CNT_W'(CMD_W)) begin
              state  <= ST_WAIT;
              oe_q   <= 1'b0;
              dout_q <= 1'b0;
              cnt    <= '0;
            end else begin
              dout_q <= cmd_sh[CMD_W-1];
              cmd_sh <= cmd_sh << 1;
              cnt    <= cnt + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (rise_evt) begin
            if (enc_din) begin
              state <= ST_RECV;
              cnt   <= '0;
            end else if (cnt == CNT_W'(TIMEOUT_P - 1)) begin
              state <= ST_IDLE;
              to_q  <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_RECV: begin
          if (rise_evt) begin
            resp_q <= {enc_din, resp_q[RESP_W-1:1]};
            cnt    <= cnt + 1'b1;
            if (cnt == CNT_W'(RESP_W - 1)) state <= ST_FIN;
          end
        end
        ST_FIN: begin
          pos_q    <= pos_w;
          f1_q     <= f1_w;
          f2_q     <= f2_w;
          crc_rx_q <= crc_rx_w;
          crc_ok_q <= (crc_acc == crc_rx_w);
          done_q   <= 1'b1;
          state    <= ST_REC;
        end
        ST_REC: begin
          if (!enc_din) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign enc_dout  = dout_q;
  assign enc_oe    = oe_q;
  assign pos_o     = pos_q;
  assign f1_o      = f1_q;
  assign f2_o      = f2_q;
  assign crc_rx_o  = crc_rx_q;
  assign crc_ok_o  = crc_ok_q;
  assign done_o    = done_q;
  assign timeout_o = to_q;

  // R4
  dout_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(enc_dout) |-> $past(fall_evt));

  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enc_oe) |-> (state == ST_WAIT));

  // R8
  crc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok_o |-> done_o);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  park_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIN) |-> sclk_o);

  // R10
  excl_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && state != ST_LATCH) |=> (state != ST_LATCH));

  // R12
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REC && enc_din) |=> (state == ST_REC));

endmodule

// File: tb/abs_enc_reader_bench.sv
module abs_enc_reader_bench;
  localparam int HALF = 2;
  localparam int TMO  = 8;
  localparam int PW   = 23;
  localparam logic [4:0] POLY = 5'h05;
  localparam logic [4:0] INIT = 5'h1F;
  localparam logic [5:0] CMD  = 6'b000111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic enc_din = 1'b0;
  logic sclk_o, enc_dout, enc_oe, f1_o, f2_o, crc_ok_o, done_o, timeout_o;
  logic [PW-1:0] pos_o;
  logic [4:0] crc_rx_o;

  int n_chk = 0;
  int n_bad = 0;
  int falls = 0;
  int cyc = 0;
  time fall_t [2];

  always #5 clk = ~clk;

  abs_enc_reader #(.HALF_DIV(HALF), .POS_W(PW), .TIMEOUT_P(TMO),
                   .CRC_POLY(POLY), .CRC_INIT(INIT)) u_abs_enc_reader (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .enc_din(enc_din),
    .sclk_o(sclk_o), .enc_dout(enc_dout), .enc_oe(enc_oe), .pos_o(pos_o),
    .f1_o(f1_o), .f2_o(f2_o), .crc_rx_o(crc_rx_o), .crc_ok_o(crc_ok_o),
    .done_o(done_o), .timeout_o(timeout_o));

  always @(negedge sclk_o) begin
    if (falls < 2) fall_t[falls] = $time;
    falls++;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // long-division check value over F1,F2,pos (arrival order)
  function automatic logic [4:0] ref_crc(input logic [PW+1:0] m);
    logic [PW+6:0] v;
    v = '0;
    for (int k = 0; k < PW + 2; k++) v[PW+6-k] = m[k];
    v[PW+6 -: 5] = v[PW+6 -: 5] ^ INIT;
    for (int i = PW + 6; i >= 5; i--)
      if (v[i]) v[i -: 6] = v[i -: 6] ^ {1'b1, POLY};
    return v[4:0];
  endfunction

  task automatic pulse_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic frame(input logic [PW-1:0] pos, input logic f1, input logic f2,
                       input logic bad, input int dly);
    logic [PW+1:0] msg;
    logic [4:0] c;
    logic [PW+6:0] bits;
    logic got;
    int fcount;
    msg = {pos, f2, f1};
    c = ref_crc(msg) ^ {4'b0, bad};
    bits = '0;
    bits[PW+1:0] = msg;
    for (int j = 0; j < 5; j++) bits[PW+2+j] = c[4-j];
    falls = 0;
    enc_din = 1'b0;
    pulse_start();
    for (int i = 0; i < 8; i++) begin
      @(posedge sclk_o); #1;
      if (i < 2) chk(enc_oe && !enc_dout, "R3 latch", {enc_oe, enc_dout}, 32'h2);
      else chk(enc_oe && (enc_dout == CMD[7-i]), "R4 command",
               {enc_oe, enc_dout}, {30'b0, 1'b1, CMD[7-i]});
      if (i == 4) pulse_start();  // R11 ignored mid-frame
    end
    chk(fall_t[1] - fall_t[0] == 2 * HALF * 10, "R2 period",
        32'(fall_t[1] - fall_t[0]), 2 * HALF * 10);
    for (int d = 0; d < dly; d++) @(negedge sclk_o);
    @(negedge sclk_o); #1 enc_din = 1'b1;
    chk(!enc_oe, "R5 turnaround", enc_oe, 0);
    for (int k = 0; k < PW + 7; k++) begin
      @(negedge sclk_o); #1 enc_din = bits[k];
    end
    got = 1'b0;
    for (int w = 0; w < 40 && !got; w++) begin
      @(negedge clk);
      if (done_o) got = 1'b1;
    end
    chk(got, "R9 done", got, 1);
    chk(pos_o == pos, "R7 position", pos_o, pos);
    chk({f1_o, f2_o} == {f1, f2}, "R7 flags", {f1_o, f2_o}, {f1, f2});
    chk(crc_rx_o == c, "R7 crc field", crc_rx_o, c);
    chk(crc_ok_o == !bad, "R8 crc_ok", crc_ok_o, !bad);
    chk(falls == 39 + dly, "R6 R9 fall count", falls, 39 + dly);
    enc_din = 1'b1;
    fcount = falls;
    @(negedge clk);
    chk(!done_o && !crc_ok_o, "R9 pulse width", {done_o, crc_ok_o}, 0);
    pulse_start();
    repeat (12) @(negedge clk);
    chk(sclk_o && falls == fcount, "R11 R12 recovery ignore", falls, fcount);
    enc_din = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [PW-1:0] lfsr;
    logic got;
    repeat (3) @(negedge clk);
    chk(sclk_o && !enc_oe && !enc_dout, "R1 reset pins",
        {sclk_o, enc_oe, enc_dout}, 3'b100);
    chk(!done_o && !crc_ok_o && !timeout_o, "R1 reset flags",
        {done_o, crc_ok_o, timeout_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sclk_o, "R2 idle high", sclk_o, 1);

    for (int d = 0; d < TMO; d++)
      frame(PW'(1) << (d * 3), d[0], d[1], 1'b0, d);
    frame('1, 1'b1, 1'b1, 1'b0, 0);
    frame('0, 1'b0, 1'b0, 1'b0, 1);
    lfsr = 23'h5A3C1;
    for (int n = 0; n < 16; n++) begin
      lfsr = {lfsr[21:0], lfsr[22] ^ lfsr[17]};
      frame(lfsr, lfsr[0], lfsr[5], n[0], n % TMO);
    end

    // R10 timeout with start bit one period too late
    falls = 0;
    enc_din = 1'b0;
    pulse_start();
    got = 1'b0;
    for (int w = 0; w < 300 && !got; w++) begin
      @(negedge clk);
      if (timeout_o) got = 1'b1;
      if (done_o) chk(1'b0, "R10 no done", 1, 0);
    end
    chk(got, "R10 timeout pulse", got, 1);
    chk(pos_o == lfsr, "R10 position kept", pos_o, lfsr);
    @(negedge clk);
    chk(!timeout_o && sclk_o, "R10 pulse and park", {timeout_o, sclk_o}, 1);
    chk(falls == 8 + TMO, "R10 fall count", falls, 8 + TMO);
    frame(23'h123456, 1'b1, 1'b0, 1'b0, TMO - 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule